// File: doc/BRIEF.md
# Sequenced Processor Core Soft-Reset Write Master

This block sits in programmable logic and drives a processor system's memory-mapped control space over the write half of an AXI4-Lite port. A rising edge on its trigger input starts a fixed series of six register writes that soft-reset one processor core, chosen by a core-select input.

The series opens the protected control space with an unlock key. It then writes the per-core reset control register four times. The first write asserts the core's reset, the second halts its clock, the third releases the reset and the fourth restarts the clock. The last write closes the space with a lock key. Only one write is in flight at any time. A non-OKAY response abandons the remaining control writes, but the block still sends the lock write.

Status is given by a busy level, a one-cycle done pulse and a sticky error flag. Addresses, keys and bit positions are parameters.

Top module: `cpu_rst_seq_master`

## Requirements
- R1: After reset, busy_o, done_o, err_o, m_awvalid, m_wvalid and m_bready are all 0.
- R2: A sequence starts only on a 0-to-1 transition of start_i while busy_o is 0. A trigger that is held high does not start a second run. A pulse that arrives while busy_o is 1 is ignored. While idle, no AW, W or B handshake signal is driven high.
- R3: A full sequence is exactly six writes, in this order: unlock at BASE_ADDR+0x008 with data 0xDF0D, four writes to BASE_ADDR+0x244, then lock at BASE_ADDR+0x004 with data 0x767B (default parameters).
- R4: For selected core k, the four control writes carry these values, in order: reset bit k; reset bit k plus clock-halt bit 4+k; clock-halt bit 4+k alone; zero. All other bits are 0. For core 0 this gives 0x01, 0x11, 0x10, 0x00. For core 1 it gives 0x02, 0x22, 0x20, 0x00.
- R5: At the start of each write, m_awvalid and m_wvalid rise in the same cycle. Each stays high, with its address or data unchanged, until its own ready is seen. Each channel is released on its own handshake.
- R6: m_bready is raised only after both the AW and W handshakes of the current write. No new AW or W is presented until that write's B handshake.
- R7: A response other than OKAY (bresp not 0) to any write before the lock write skips the remaining control writes. The next write is the lock write, and err_o is 1 from the cycle after that response.
- R8: err_o stays 1 while idle and is cleared only when a new trigger is accepted.
- R9: done_o is high for exactly one cycle, in the cycle after the lock write's B handshake. busy_o falls in that same cycle.
- R10: Every write uses m_awprot = 0 and m_wstrb all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Trigger; acts on its rising edge |
| core_sel_i | input | SEL_W | Index of the core to reset |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle pulse when the sequence ends |
| err_o | output | 1 | Sticky flag: a write got a non-OKAY response |
| m_awvalid | output | 1 | Write address valid |
| m_awready | input | 1 | Write address ready |
| m_awaddr | output | ADDR_W | Write address |
| m_awprot | output | 3 | Protection type, always 0 |
| m_wvalid | output | 1 | Write data valid |
| m_wready | input | 1 | Write data ready |
| m_wdata | output | DATA_W | Write data |
| m_wstrb | output | DATA_W/8 | Byte strobes, always all ones |
| m_bvalid | input | 1 | Write response valid |
| m_bready | output | 1 | Write response ready |
| m_bresp | input | 2 | Write response code |

## Verification
The assertions check the channel rules on every cycle:
- AW and W rise together and are held stable until ready.
- No new request is presented while a response is pending, and nothing is driven while idle.
- The error flag follows a bad response and stays set while idle.
- The done pulse lasts one cycle, and protection and strobes stay fixed.

The exact address and data of each of the six writes, their order for each core, the shortened path after an error, and the handling of repeated or held triggers can only be seen from the bench's scenarios. The bench logs every write its responder accepts and compares the log against lists it computes itself. Its responder applies different ready delays on the AW and W channels so that the two channels finish their handshakes in different cycles.

// File: rtl/cpu_rst_seq_master.sv
module cpu_rst_seq_master #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int NCORE = 2,
  parameter int RST_LSB = 0,
  parameter int HALT_LSB = 4,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 32'h4000_0000,
  parameter logic [ADDR_W-1:0] CTRL_OFS = 'h244,
  parameter logic [ADDR_W-1:0] LOCK_OFS = 'h004,
  parameter logic [ADDR_W-1:0] UNLOCK_OFS = 'h008,
  parameter logic [DATA_W-1:0] LOCK_KEY = 'h767B,
  parameter logic [DATA_W-1:0] UNLOCK_KEY = 'hDF0D,
  localparam int SEL_W = (NCORE > 1) ? $clog2(NCORE) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [SEL_W-1:0]  core_sel_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o,
  output logic              m_awvalid,
  input  logic              m_awready,
  output logic [ADDR_W-1:0] m_awaddr,
  output logic [2:0]        m_awprot,
  output logic              m_wvalid,
  input  logic              m_wready,
  output logic [DATA_W-1:0] m_wdata,
  output logic [DATA_W/8-1:0] m_wstrb,
  input  logic              m_bvalid,
  output logic              m_bready,
  input  logic [1:0]        m_bresp
);
  localparam logic [2:0] LAST = 3'd5;
  localparam logic [ADDR_W-1:0] A_CTRL = BASE_ADDR + CTRL_OFS;
  localparam logic [ADDR_W-1:0] A_LOCK = BASE_ADDR + LOCK_OFS;
  localparam logic [ADDR_W-1:0] A_UNLOCK = BASE_ADDR + UNLOCK_OFS;

  logic [2:0] step;
  logic [SEL_W-1:0] sel_q;
  logic start_q;
  logic [DATA_W-1:0] rst_bit, halt_bit;

  wire rise = start_i & ~start_q;
  wire aw_left = m_awvalid & ~m_awready;
  wire w_left = m_wvalid & ~m_wready;
  wire b_ok = m_bvalid & m_bready;
  wire bad = m_bresp != 2'b00;

  assign rst_bit = DATA_W'(1) << (RST_LSB + int'(sel_q));
  assign halt_bit = DATA_W'(1) << (HALT_LSB + int'(sel_q));
  assign m_awprot = 3'b000;
  assign m_wstrb = '1;

  always_comb begin
    m_awaddr = A_CTRL;
    m_wdata = '0;
    case (step)
      3'd0: begin m_awaddr = A_UNLOCK; m_wdata = UNLOCK_KEY; end
      3'd1: m_wdata = rst_bit;
      3'd2: m_wdata = rst_bit | halt_bit;
      3'd3: m_wdata = halt_bit;
      3'd4: m_wdata = '0;
      default: begin m_awaddr = A_LOCK; m_wdata = LOCK_KEY; end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= 1'b0;
      busy_o <= 1'b0;
      done_o <= 1'b0;
      err_o <= 1'b0;
      step <= 3'd0;
      sel_q <= '0;
      m_awvalid <= 1'b0;
      m_wvalid <= 1'b0;
      m_bready <= 1'b0;
    end else begin
      start_q <= start_i;
      done_o <= 1'b0;
      if (!busy_o) begin
        if (rise) begin
          busy_o <= 1'b1;
          err_o <= 1'b0;
          step <= 3'd0;
          sel_q <= core_sel_i;
          m_awvalid <= 1'b1;
          m_wvalid <= 1'b1;
        end
      end else begin
        if (m_awvalid && m_awready) m_awvalid <= 1'b0;
        if (m_wvalid && m_wready) m_wvalid <= 1'b0;
        if (!m_bready && (m_awvalid || m_wvalid) && !aw_left && !w_left)
          m_bready <= 1'b1;
        if (b_ok) begin
          m_bready <= 1'b0;
          if (bad) err_o <= 1'b1;
          if (step == LAST) begin
            busy_o <= 1'b0;
            done_o <= 1'b1;
          end else begin
            m_awvalid <= 1'b1;
            m_wvalid <= 1'b1;
            step <= bad ? LAST : step + 3'd1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/cpu_rst_seq_master_chk.sv
module cpu_rst_seq_master_chk #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input logic clk,
  input logic rst_n,
  input logic busy_o,
  input logic done_o,
  input logic err_o,
  input logic m_awvalid,
  input logic m_awready,
  input logic [ADDR_W-1:0] m_awaddr,
  input logic [2:0] m_awprot,
  input logic m_wvalid,
  input logic m_wready,
  input logic [DATA_W-1:0] m_wdata,
  input logic [DATA_W/8-1:0] m_wstrb,
  input logic m_bvalid,
  input logic m_bready,
  input logic [1:0] m_bresp
);
  assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> !m_awvalid && !m_wvalid && !m_bready);
  assert_aw_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    m_awvalid && !m_awready |=> m_awvalid && $stable(m_awaddr));
  assert_w_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    m_wvalid && !m_wready |=> m_wvalid && $stable(m_wdata));
  assert_pair_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(m_awvalid) |-> $rose(m_wvalid));
  assert_one_out_R6: assert property (@(posedge clk) disable iff (!rst_n)
    m_bready |-> !m_awvalid && !m_wvalid);
  assert_bad_resp_R7: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o && m_bvalid && m_bready && m_bresp != 2'b00 |=> err_o);
  assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    err_o && !busy_o |=> err_o || busy_o);
  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o ##1 !done_o);
  assert_fixed_attr_R10: assert property (@(posedge clk) disable iff (!rst_n)
    m_awvalid |-> m_awprot == 3'b000 && m_wstrb == '1);
endmodule

bind cpu_rst_seq_master cpu_rst_seq_master_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy_o(busy_o), .done_o(done_o), .err_o(err_o),
  .m_awvalid(m_awvalid), .m_awready(m_awready), .m_awaddr(m_awaddr), .m_awprot(m_awprot),
  .m_wvalid(m_wvalid), .m_wready(m_wready), .m_wdata(m_wdata), .m_wstrb(m_wstrb),
  .m_bvalid(m_bvalid), .m_bready(m_bready), .m_bresp(m_bresp));

// File: tb/sim_cpu_rst_seq_master.sv
module sim_cpu_rst_seq_master;
  localparam logic [31:0] BASE = 32'h4000_0000;
  logic clk = 1'b0, rst_n = 1'b0, start_i = 1'b0;
  logic [0:0] core_sel_i = 1'b0;
  logic busy_o, done_o, err_o;
  logic m_awvalid, m_wvalid, m_bready;
  logic m_awready, m_wready, m_bvalid;
  logic [31:0] m_awaddr, m_wdata;
  logic [2:0] m_awprot;
  logic [3:0] m_wstrb;
  logic [1:0] m_bresp;

  always #10 clk = ~clk;

  cpu_rst_seq_master u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .core_sel_i(core_sel_i),
    .busy_o(busy_o), .done_o(done_o), .err_o(err_o),
    .m_awvalid(m_awvalid), .m_awready(m_awready), .m_awaddr(m_awaddr), .m_awprot(m_awprot),
    .m_wvalid(m_wvalid), .m_wready(m_wready), .m_wdata(m_wdata), .m_wstrb(m_wstrb),
    .m_bvalid(m_bvalid), .m_bready(m_bready), .m_bresp(m_bresp));

  int checks = 0, fails = 0;
  int aw_lat = 0, w_lat = 0, aw_wait, w_wait, wcount, viol;
  logic got_aw, got_w, clr, prev_aw;
  logic [31:0] cap_a [16];
  logic [31:0] cap_d [16];
  logic [1:0] resp_tab [8];

  always @(posedge clk) begin
    if (!rst_n || clr) begin
      m_awready <= 0; m_wready <= 0; m_bvalid <= 0; m_bresp <= 0;
      got_aw <= 0; got_w <= 0; aw_wait <= 0; w_wait <= 0; wcount <= 0;
    end else begin
      if (m_awvalid && m_awready) begin
        got_aw <= 1; m_awready <= 0; aw_wait <= 0;
        if (wcount < 16) cap_a[wcount] <= m_awaddr;
      end else if (m_awvalid && !got_aw) begin
        if (aw_wait >= aw_lat) m_awready <= 1; else aw_wait <= aw_wait + 1;
      end
      if (m_wvalid && m_wready) begin
        got_w <= 1; m_wready <= 0; w_wait <= 0;
        if (wcount < 16) cap_d[wcount] <= m_wdata;
      end else if (m_wvalid && !got_w) begin
        if (w_wait >= w_lat) m_wready <= 1; else w_wait <= w_wait + 1;
      end
      if (got_aw && got_w && !m_bvalid) begin
        m_bvalid <= 1;
        m_bresp <= (wcount < 8) ? resp_tab[wcount] : 2'b00;
      end
      if (m_bvalid && m_bready) begin
        m_bvalid <= 0; got_aw <= 0; got_w <= 0; wcount <= wcount + 1;
      end
    end
  end

  always @(negedge clk) begin
    if (!rst_n || clr) begin viol <= 0; prev_aw <= 0; end
    else begin
      if ((m_awvalid && got_aw) || (m_wvalid && got_w)) viol <= viol + 1;
      if (m_bready && !(got_aw && got_w)) viol <= viol + 1;
      if (m_awvalid && !prev_aw && !m_wvalid) viol <= viol + 1;
      if (m_awvalid && (m_awprot != 0 || m_wstrb != 4'hF)) viol <= viol + 1;
      prev_aw <= m_awvalid;
    end
  end

  task automatic chk(input bit ok, input string req, input string what, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_addr(input int s);
    if (s == 0) return BASE + 32'h008;
    if (s == 5) return BASE + 32'h004;
    return BASE + 32'h244;
  endfunction

  function automatic logic [31:0] exp_data(input int s, input int k);
    case (s)
      0: return 32'hDF0D;
      1: return 32'h1 << k;
      2: return (32'h1 << k) | (32'h1 << (4 + k));
      3: return 32'h1 << (4 + k);
      4: return 32'h0;
      default: return 32'h767B;
    endcase
  endfunction

  task automatic clear_log(input int awl, input int wl);
    @(negedge clk); clr = 1; aw_lat = awl; w_lat = wl;
    @(negedge clk); clr = 0;
  endtask

  task automatic pulse_start;
    start_i = 1; @(negedge clk); start_i = 0;
  endtask

  task automatic wait_done(output bit seen);
    seen = 0;
    for (int i = 0; i < 400 && !seen; i++) begin
      @(negedge clk);
      if (done_o) seen = 1;
    end
    chk(seen, "R9", "done seen", seen, 1);
    chk(busy_o == 0, "R9", "busy low with done", busy_o, 0);
    @(negedge clk);
    chk(done_o == 0, "R9", "done one cycle", done_o, 0);
  endtask

  task automatic check_log(input int k, input int bad_at);
    int n;
    n = (bad_at < 0) ? 6 : bad_at + 2;
    chk(wcount == n, "R3", "write count", wcount, n);
    for (int i = 0; i < n && i < 16; i++) begin
      int s;
      s = (bad_at >= 0 && i == n - 1) ? 5 : i;
      chk(cap_a[i] == exp_addr(s), "R3", "address", cap_a[i], exp_addr(s));
      chk(cap_d[i] == exp_data(s, k), (s >= 1 && s <= 4) ? "R4" : "R3", "data", cap_d[i], exp_data(s, k));
    end
    chk(viol == 0, "R6", "channel order violations (R5/R10 too)", viol, 0);
  endtask

  task automatic t_reset;
    chk(busy_o == 0 && done_o == 0 && err_o == 0, "R1", "status after reset", {busy_o, done_o, err_o}, 0);
    chk(m_awvalid == 0 && m_wvalid == 0 && m_bready == 0, "R1", "channels after reset",
        {m_awvalid, m_wvalid, m_bready}, 0);
  endtask

  task automatic t_seq(input int k, input int awl, input int wl, input bit poke);
    bit seen;
    clear_log(awl, wl);
    core_sel_i = 1'(k);
    pulse_start;
    chk(busy_o == 1, "R2", "busy after trigger", busy_o, 1);
    chk(err_o == 0, "R8", "err cleared on accept", err_o, 0);
    if (poke) begin
      repeat (3) @(negedge clk);
      core_sel_i = 1'(~k[0]);
      pulse_start;
    end
    wait_done(seen);
    chk(err_o == 0, "R7", "no error on clean run", err_o, 0);
    repeat (5) @(negedge clk);
    chk(busy_o == 0, "R2", "no restart from ignored pulse", busy_o, 0);
    check_log(k, -1);
  endtask

  task automatic t_err(input int at);
    bit seen;
    clear_log(1, 0);
    resp_tab[at] = 2'b10;
    core_sel_i = 1'b1;
    pulse_start;
    wait_done(seen);
    chk(err_o == 1, "R7", "err after bad response", err_o, 1);
    check_log(1, at);
    repeat (20) @(negedge clk);
    chk(err_o == 1, "R8", "err sticky while idle", err_o, 1);
    resp_tab[at] = 2'b00;
  endtask

  task automatic t_level;
    bit seen;
    clear_log(0, 2);
    core_sel_i = 1'b0;
    start_i = 1;
    @(negedge clk);
    wait_done(seen);
    repeat (30) @(negedge clk);
    chk(busy_o == 0, "R2", "held trigger does not restart", busy_o, 0);
    chk(wcount == 6, "R2", "writes with held trigger", wcount, 6);
    start_i = 0;
    @(negedge clk);
  endtask

  initial begin
    clr = 0;
    for (int i = 0; i < 8; i++) resp_tab[i] = 2'b00;
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_seq(0, 0, 0, 0);
    t_seq(1, 2, 0, 0);
    t_seq(0, 0, 3, 1);
    t_seq(1, 1, 1, 1);
    t_err(2);
    t_seq(1, 0, 1, 0);
    t_err(0);
    t_err(4);
    t_level;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule